// File: doc/BRIEF.md
# Password-Gated Configuration Register Bank

This block holds seven byte-wide configuration registers behind a small I/O bus with a 12-bit address, an 8-bit data path and separate read and write strobes. Out of reset the bank is locked: reads from its window return all ones, as an undriven bus would, and writes have no effect. Software unlocks it by writing a one-byte unlock code to the code address, which sits at the same address as the third register. That write opens the gate for exactly one later access to the register window. The access is served, and the gate locks again.

A parameter picks one of four variants. The variant sets the unlock code. One variant hardwires identification bits into the third register. The indexed variant can leave the gated scheme for good. A code write followed by a fixed switch byte moves it to an index/data port pair. From then on the registers are reached with no code, and the old window goes dead. A read drives the data bus only when the read strobe is high and the address belongs to the block.

Top module: `cfg_gate_bank`

## Requirements
- R1: After reset every register holds 0x00 (the third register of the identification variant reads 0x03), the gate is locked and the indexed mode is off, so the index and data ports do not respond.
- R2: While the gate is locked, a read of any address 0xF8D..0xF93 returns 0xFF and a write there changes no register.
- R3: A write of the variant's unlock code to 0xF8F opens the gate, and that write is not itself a register access. The next read or write of an address in 0xF8D..0xF93 is served, and the gate locks again after it. Accesses outside that window do not close the gate.
- R4: The unlock code is 0xE2 for the basic and identification variants, 0xE3 for the newer variant and 0xE4 for the indexed variant. Any other byte written to 0xF8F while locked leaves the gate locked.
- R5: Through an open gate, each register stores and returns a full byte, including bit 7 of the register at 0xF8D.
- R6: On the identification variant, bits [1:0] of the register at 0xF8F always read 0b11 and ignore writes, while bits [7:2] store written values.
- R7: On the indexed variant, writing 0x80 to 0xF8F as the one access of an open gate switches permanently to indexed mode and writes no register. In indexed mode the window 0xF8D..0xF93 reads 0xFF and ignores writes, and unlock codes have no effect.
- R8: In indexed mode a write to 0xE0E stores an index byte that reads back at 0xE0E. Reads and writes of 0xE0F reach the register whose window address is 0xF8C plus the index, with no unlock code. An index outside 1..7 reads 0xFF at 0xE0F and ignores writes there.
- R9: io_oe is high exactly in cycles where io_rd is high and the address hits the block (the window, or 0xE0E/0xE0F in indexed mode), and io_rdata is 0x00 whenever io_oe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | 12 | I/O address |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe, one access per high cycle |
| io_wr | input | 1 | Write strobe, one access per high cycle |
| io_rdata | output | 8 | Read data, valid while io_oe is high |
| io_oe | output | 1 | Data bus drive enable |

## Verification
The bench drives one bus into all four variants at once. Each variant therefore sees codes meant for the others, and a design that accepted a foreign code would return stored bytes where 0xFF is due. It places accesses outside the window between the unlock and the served access. A gate that closed on any bus cycle would then lock too early, and one that counted the code write as its access would never serve a register at all. It also checks a second access after an unlock, the switch byte on variants without indexed mode, index values 0 and 8, and the dead window after the switch. Errors here show up as a gate left open, a stray write to the third register, or a write past the register range. A final reset shows that indexed mode does not survive reset.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;

  typedef enum logic [1:0] {
    VAR_BASIC   = 2'd0,
    VAR_IDCODE  = 2'd1,
    VAR_PLUS    = 2'd2,
    VAR_INDEXED = 2'd3
  } variant_e;

  typedef enum logic [1:0] {
    GATE_LOCKED  = 2'd0,
    GATE_OPEN    = 2'd1,
    GATE_INDEXED = 2'd2
  } gate_e;

  localparam int         CFG_DW      = 8;
  localparam int         ID_REG      = 2;
  localparam logic [7:0] ID_MASK     = 8'h03;
  localparam logic [7:0] SWITCH_CODE = 8'h80;

  function automatic logic [CFG_DW-1:0] unlock_code(input variant_e v);
    case (v)
      VAR_PLUS:    unlock_code = 8'hE3;
      VAR_INDEXED: unlock_code = 8'hE4;
      default:     unlock_code = 8'hE2;
    endcase
  endfunction

endpackage

// File: rtl/cfg_gate_decode.sv
module cfg_gate_decode #(
  parameter int                ADDR_W   = 12,
  parameter int                DATA_W   = 8,
  parameter int                NUM_REGS = 7,
  parameter logic [ADDR_W-1:0] BASE     = 12'hF8D,
  parameter logic [ADDR_W-1:0] PW_ADDR  = 12'hF8F,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 12'hE0E,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 12'hE0F,
  localparam int               SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] idx_q,
  output logic              in_win,
  output logic [SEL_W-1:0]  win_sel,
  output logic              at_pw,
  output logic              at_idx,
  output logic              at_dat,
  output logic              idx_ok,
  output logic [SEL_W-1:0]  idx_sel
);

  assign at_pw  = (addr == PW_ADDR);
  assign at_idx = (addr == IDX_ADDR);
  assign at_dat = (addr == DAT_ADDR);

  always_comb begin
    in_win  = 1'b0;
    win_sel = '0;
    idx_ok  = 1'b0;
    idx_sel = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (addr == ADDR_W'(int'(BASE) + k)) begin
        in_win  = 1'b1;
        win_sel = SEL_W'(k);
      end
      if (idx_q == DATA_W'(k + 1)) begin
        idx_ok  = 1'b1;
        idx_sel = SEL_W'(k);
      end
    end
  end

endmodule

// File: rtl/cfg_gate_fsm.sv
module cfg_gate_fsm
  import cfg_gate_pkg::*;
#(
  parameter variant_e VARIANT = VAR_INDEXED
) (
  input  logic clk,
  input  logic rst_n,
  input  logic unlock_hit,
  input  logic win_access,
  input  logic switch_req,
  output logic gate_open,
  output logic idx_mode
);

  localparam logic CAN_SWITCH = (VARIANT == VAR_INDEXED);

  gate_e state_q, state_d;
  logic  state_en;

  always_comb begin
    state_d = state_q;
    case (state_q)
      GATE_LOCKED:  if (unlock_hit) state_d = GATE_OPEN;
      GATE_OPEN:    if (win_access)
                      state_d = (CAN_SWITCH && switch_req) ? GATE_INDEXED : GATE_LOCKED;
      GATE_INDEXED: state_d = GATE_INDEXED;
      default:      state_d = GATE_LOCKED;
    endcase
  end

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= GATE_LOCKED;
    else if (state_en) state_q <= state_d;
  end

  assign gate_open = (state_q == GATE_OPEN);
  assign idx_mode  = (state_q == GATE_INDEXED);

  // R3: an open gate serves one window access, then it is shut
  a_r3_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && win_access) |=> !gate_open);

  // R4: the gate never opens without an unlock write
  a_r4_open_needs_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_open && !unlock_hit) |=> !gate_open);

  // R7: indexed mode is permanent
  a_r7_indexed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    idx_mode |=> idx_mode);

endmodule

// File: rtl/cfg_gate_regs.sv
module cfg_gate_regs
  import cfg_gate_pkg::*;
#(
  parameter variant_e VARIANT  = VAR_INDEXED,
  parameter int       NUM_REGS = 7,
  parameter int       DATA_W   = 8,
  localparam int      SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [SEL_W-1:0]           sel,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_REGS*DATA_W-1:0] rd_flat
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] FIXED =
      (VARIANT == VAR_IDCODE && g == ID_REG) ? DATA_W'(ID_MASK) : '0;

    logic [DATA_W-1:0] q;
    logic              en;

    assign en = we && (sel == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata & ~FIXED;
    end

    assign rd_flat[g*DATA_W +: DATA_W] = q | FIXED;
  end

endmodule

// File: rtl/cfg_gate_bank.sv
module cfg_gate_bank
  import cfg_gate_pkg::*;
#(
  parameter variant_e          VARIANT  = VAR_INDEXED,
  parameter int                ADDR_W   = 12,
  parameter int                NUM_REGS = 7,
  parameter logic [ADDR_W-1:0] BASE     = 12'hF8D,
  parameter logic [ADDR_W-1:0] PW_ADDR  = 12'hF8F,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 12'hE0E,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 12'hE0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [7:0]        io_rdata,
  output logic              io_oe
);

  localparam int                DATA_W  = CFG_DW;
  localparam int                SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [DATA_W-1:0] CODE    = unlock_code(VARIANT);
  localparam logic [DATA_W-1:0] FLOAT   = '1;
  localparam logic              IS_IDX  = (VARIANT == VAR_INDEXED);

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic                       in_win, at_pw, at_idx, at_dat, idx_ok;
  logic [SEL_W-1:0]           win_sel, idx_sel;
  logic [DATA_W-1:0]          idx_q;
  logic                       gate_open, idx_mode;
  logic                       unlock_hit, switch_req, win_access;
  logic                       win_we, dat_we, idx_we, reg_we, hit;
  logic [SEL_W-1:0]           reg_sel;
  logic [NUM_REGS*DATA_W-1:0] rd_flat;
  logic [DATA_W-1:0]          rdata_d;

  cfg_gate_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BASE(BASE),
    .PW_ADDR(PW_ADDR), .IDX_ADDR(IDX_ADDR), .DAT_ADDR(DAT_ADDR)
  ) u_decode (
    .addr(io_addr), .idx_q(idx_q), .in_win(in_win), .win_sel(win_sel),
    .at_pw(at_pw), .at_idx(at_idx), .at_dat(at_dat),
    .idx_ok(idx_ok), .idx_sel(idx_sel)
  );

  assign unlock_hit = io_wr && at_pw && (io_wdata == CODE);
  assign switch_req = io_wr && at_pw && (io_wdata == DATA_W'(SWITCH_CODE));
  assign win_access = (io_rd || io_wr) && in_win;

  cfg_gate_fsm #(.VARIANT(VARIANT)) u_fsm (
    .clk(clk), .rst_n(rst_core_n), .unlock_hit(unlock_hit),
    .win_access(win_access), .switch_req(switch_req),
    .gate_open(gate_open), .idx_mode(idx_mode)
  );

  assign win_we  = io_wr && in_win && gate_open && !(IS_IDX && switch_req);
  assign dat_we  = io_wr && at_dat && idx_mode && idx_ok;
  assign idx_we  = io_wr && at_idx && idx_mode;
  assign reg_we  = win_we || dat_we;
  assign reg_sel = idx_mode ? idx_sel : win_sel;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  idx_q <= '0;
    else if (idx_we)  idx_q <= io_wdata;
  end

  cfg_gate_regs #(
    .VARIANT(VARIANT), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_core_n), .we(reg_we), .sel(reg_sel),
    .wdata(io_wdata), .rd_flat(rd_flat)
  );

  function automatic logic [DATA_W-1:0] pick(input logic [NUM_REGS*DATA_W-1:0] f,
                                             input logic [SEL_W-1:0] s);
    pick = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (s == SEL_W'(k)) pick = f[k*DATA_W +: DATA_W];
  endfunction

  assign hit   = in_win || (idx_mode && (at_idx || at_dat));
  assign io_oe = io_rd && hit;

  always_comb begin
    rdata_d = '0;
    if (io_oe) begin
      if (in_win)      rdata_d = gate_open ? pick(rd_flat, win_sel) : FLOAT;
      else if (at_idx) rdata_d = idx_q;
      else             rdata_d = idx_ok ? pick(rd_flat, idx_sel) : FLOAT;
    end
  end
  assign io_rdata = rdata_d;

  // R9: the bus is driven only for reads
  a_r9_oe_only_on_read: assert property (@(posedge clk) disable iff (!rst_core_n)
    io_oe |-> io_rd);

  // R2: a write with the gate shut changes no stored byte
  a_r2_locked_no_write: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!gate_open && !idx_mode && io_wr) |=> $stable(rd_flat));

  // R7: after the switch, the old window floats
  a_r7_window_dead: assert property (@(posedge clk) disable iff (!rst_core_n)
    (idx_mode && io_rd && in_win) |-> (io_rdata == FLOAT));

endmodule

// File: tb/cfg_gate_bank_bench.sv
`timescale 1ns/1ps
module cfg_gate_bank_bench;
  import cfg_gate_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] io_addr;
  logic [7:0]  io_wdata;
  logic        io_rd, io_wr;
  logic [7:0]  rdata [4];
  logic        oe    [4];

  always #2.5 clk = ~clk;

  // model index: 0 basic, 1 id-code, 2 plus, 3 indexed
  cfg_gate_bank #(.VARIANT(VAR_BASIC)) u_cfg_gate_bank_basic (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_rdata(rdata[0]), .io_oe(oe[0]));
  cfg_gate_bank #(.VARIANT(VAR_IDCODE)) u_cfg_gate_bank_id (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_rdata(rdata[1]), .io_oe(oe[1]));
  cfg_gate_bank #(.VARIANT(VAR_PLUS)) u_cfg_gate_bank_plus (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_rdata(rdata[2]), .io_oe(oe[2]));
  cfg_gate_bank #(.VARIANT(VAR_INDEXED)) u_cfg_gate_bank (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_rdata(rdata[3]), .io_oe(oe[3]));

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  string tag = "R9";

  // behavioural model: 0 locked, 1 open, 2 indexed
  int mem [4][8];
  int st  [4];
  int ix  [4];

  function automatic int code_of(int v);
    return (v == 2) ? 'hE3 : (v == 3) ? 'hE4 : 'hE2;
  endfunction

  function automatic int val_of(int v, int k);
    return (v == 1 && k == 3) ? (mem[v][k] | 3) : mem[v][k];
  endfunction

  task automatic model_reset();
    for (int v = 0; v < 4; v++) begin
      st[v] = 0; ix[v] = 0;
      for (int k = 0; k < 8; k++) mem[v][k] = 0;
    end
  endtask

  task automatic model_step(logic rd, logic wr, int a, int d);
    for (int v = 0; v < 4; v++) begin
      bit win = (a >= 'hF8D) && (a <= 'hF93);
      if (st[v] == 0) begin
        if (wr && a == 'hF8F && d == code_of(v)) st[v] = 1;
      end else if (st[v] == 1) begin
        if ((rd || wr) && win) begin
          if (v == 3 && wr && a == 'hF8F && d == 'h80) st[v] = 2;
          else begin
            if (wr) mem[v][a - 'hF8C] = (v == 1 && a == 'hF8F) ? (d & 'hFC) : d;
            st[v] = 0;
          end
        end
      end else begin
        if (wr && a == 'hE0E) ix[v] = d;
        if (wr && a == 'hE0F && ix[v] >= 1 && ix[v] <= 7) mem[v][ix[v]] = d;
      end
    end
  endtask

  task automatic check_now(logic rd, int a);
    for (int v = 0; v < 4; v++) begin
      bit win = (a >= 'hF8D) && (a <= 'hF93);
      logic       eoe = 1'b0;
      logic [7:0] eq  = 8'h00;
      if (rd && win) begin
        eoe = 1'b1;
        eq  = (st[v] == 1) ? 8'(val_of(v, a - 'hF8C)) : 8'hFF;
      end else if (rd && st[v] == 2 && a == 'hE0E) begin
        eoe = 1'b1; eq = 8'(ix[v]);
      end else if (rd && st[v] == 2 && a == 'hE0F) begin
        eoe = 1'b1;
        eq  = (ix[v] >= 1 && ix[v] <= 7) ? 8'(val_of(v, ix[v])) : 8'hFF;
      end
      checks++;
      if (oe[v] !== eoe || rdata[v] !== eq) begin
        failures++;
        $display("FAIL %s variant=%0d addr=%h oe=%b rdata=%h expected oe=%b rdata=%h",
                 tag, v, a[11:0], oe[v], rdata[v], eoe, eq);
      end
    end
  endtask

  task automatic cyc(logic rd, logic wr, logic [11:0] a, logic [7:0] d);
    @(negedge clk);
    io_rd = rd; io_wr = wr; io_addr = a; io_wdata = d;
    #1;
    check_now(rd, int'(a));
    @(posedge clk);
    model_step(rd, wr, int'(a), int'(d));
  endtask

  task automatic rd(logic [11:0] a);                 cyc(1'b1, 1'b0, a, 8'h00); endtask
  task automatic wr(logic [11:0] a, logic [7:0] d);  cyc(1'b0, 1'b1, a, d);     endtask
  task automatic idle();                             cyc(1'b0, 1'b0, 12'h000, 8'h00); endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; io_rd = 1'b0; io_wr = 1'b0; io_addr = '0; io_wdata = '0;
    model_reset();
    repeat (3) idle();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle();
  endtask

  task automatic unlock_all();
    wr(12'hF8F, 8'hE2); wr(12'hF8F, 8'hE3); wr(12'hF8F, 8'hE4);
  endtask

  initial begin
    rst_n = 1'b0; io_rd = 1'b0; io_wr = 1'b0; io_addr = '0; io_wdata = '0;
    do_reset();

    tag = "R2";  // locked reads float, locked writes dropped
    for (int a = 'hF8D; a <= 'hF93; a++) rd(12'(a));
    wr(12'hF8D, 8'h55); wr(12'hF91, 8'hAA);

    tag = "R1";  // reset values, reached one unlock at a time
    for (int a = 'hF8D; a <= 'hF93; a++) begin
      wr(12'hF8F, 8'hE2); rd(12'(a));
      wr(12'hF8F, 8'hE3); rd(12'(a));
      wr(12'hF8F, 8'hE4); rd(12'(a));
    end
    rd(12'hE0E); rd(12'hE0F);

    tag = "R4";  // wrong codes leave each variant locked
    wr(12'hF8F, 8'hE1); rd(12'hF8D);
    wr(12'hF8F, 8'hE5); rd(12'hF8D);
    wr(12'hF8F, 8'h00); rd(12'hF8D);
    wr(12'hF8F, 8'hE3); rd(12'hF8E);

    tag = "R3";  // one served access, outside accesses do not count
    wr(12'hF8F, 8'hE2);
    rd(12'hF8C); rd(12'hE0E); wr(12'hF94, 8'h11); idle();
    wr(12'hF8D, 8'h80);
    wr(12'hF8D, 8'h7F);
    rd(12'hF8D);
    wr(12'hF8F, 8'hE2); rd(12'hF8D); rd(12'hF8D);

    tag = "R5";  // full byte storage in every register
    for (int a = 'hF8D; a <= 'hF93; a++) begin
      unlock_all();
      wr(12'hF8F, 8'hE2); wr(12'(a), 8'(8'hA5 ^ a[7:0]));
      wr(12'hF8F, 8'hE3); wr(12'(a), 8'(8'h5A ^ a[7:0]));
    end
    for (int a = 'hF8D; a <= 'hF93; a++) begin
      wr(12'hF8F, 8'hE2); rd(12'(a));
      wr(12'hF8F, 8'hE3); rd(12'(a));
    end
    wr(12'hF8F, 8'hE2); rd(12'hF8D);
    wr(12'hF8F, 8'hE2); wr(12'hF8D, 8'h00);
    wr(12'hF8F, 8'hE2); rd(12'hF8D);

    tag = "R6";  // hardwired id bits on the third register
    wr(12'hF8F, 8'hE2); wr(12'hF8F, 8'h00);
    wr(12'hF8F, 8'hE2); rd(12'hF8F);
    wr(12'hF8F, 8'hE2); wr(12'hF8F, 8'hFC);
    wr(12'hF8F, 8'hE2); rd(12'hF8F);
    wr(12'hF8F, 8'hE2); wr(12'hF8F, 8'h50);
    wr(12'hF8F, 8'hE2); rd(12'hF8F);

    tag = "R7";  // switch to indexed mode
    wr(12'hF8F, 8'hE2); wr(12'hF8F, 8'h80);   // not a switch on basic/id
    wr(12'hF8F, 8'hE2); rd(12'hF8F);
    wr(12'hF8F, 8'hE4); wr(12'hF8F, 8'h80);
    for (int a = 'hF8D; a <= 'hF93; a++) rd(12'(a));
    wr(12'hF8F, 8'hE4); rd(12'hF8F); wr(12'hF8D, 8'h33);
    wr(12'hF8F, 8'hE4); wr(12'hF8F, 8'h80); rd(12'hF8F);

    tag = "R8";  // index/data pair
    wr(12'hE0E, 8'h07); rd(12'hE0E);
    wr(12'hE0F, 8'h00); rd(12'hE0F);
    wr(12'hE0F, 8'hCB); rd(12'hE0F);
    wr(12'hE0E, 8'h01); rd(12'hE0F);
    wr(12'hE0E, 8'h03); rd(12'hE0F); wr(12'hE0F, 8'h3C); rd(12'hE0F);
    wr(12'hE0E, 8'h00); rd(12'hE0F); wr(12'hE0F, 8'h99); rd(12'hE0F);
    wr(12'hE0E, 8'h08); wr(12'hE0F, 8'h66); rd(12'hE0F);
    for (int i = 1; i <= 7; i++) begin wr(12'hE0E, 8'(i)); rd(12'hE0F); end

    tag = "R9";  // drive enable only for reads that hit
    idle(); rd(12'hF8C); rd(12'hF94); rd(12'h000); wr(12'hE0F, 8'h12);
    rd(12'hE0E); rd(12'hE0F); idle();

    tag = "R1";  // reset leaves indexed mode and clears storage
    do_reset();
    rd(12'hE0E); rd(12'hE0F); rd(12'hF8D);
    wr(12'hF8F, 8'hE4); rd(12'hF93);
    wr(12'hF8F, 8'hE2); rd(12'hF8F);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired, expected the run to end before it");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule